// File: doc/BRIEF.md
# Open-drain pin adapter with power-up bus recovery

This block joins an I2C master core, which presents separate output, tristate-enable and input signals for SDA and SCL, to a companion logic device that is wired with three one-way lines: SDA toward the device, SCL toward the device, and SDA back from it. Open-drain behaviour is emulated by ORing each output with its tristate enable, so a released line drives high. The SCL value sent out is also looped back to the core as its SCL input. The SDA value returned to the core is the companion's SDA return ANDed with an optional secondary-bus SDA input, which is tied high when unused.

A responder behind the companion device may hold the returned SDA low after power-up until it sees a falling SCL edge. A core that waits for the bus to go busy would then hang. To prevent this, the block runs a recovery sequence after every synchronous reset and on every one-cycle recovery request. The sequence toggles both outgoing lines a set number of times and then issues a STOP condition. During the sequence the core's outputs are ignored and its inputs read high. When the sequence is over, the block hands the pins to the core and raises `ready`. If the returned SDA is still low at that point, a sticky `fault` flag is set, and `ready` rises anyway.

All outputs are registered. `TOGGLES` sets the number of toggle cycles (default 9). `HALF_CYCLES` sets the clock count of each half-period and of each STOP phase.

Top module: `twi_line_mender`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs become: `pin_sda_out`=1, `pin_scl_out`=1, `core_sda_i`=1, `core_scl_i`=1, `ready`=0, `fault`=0.
- R2: Let E0 be the edge at which `rst` or `recover_req` is sampled high. From the edge after E0, the outgoing lines show `TOGGLES` cycles. Each cycle is two phases of `HALF_CYCLES` clocks: first SDA=0 and SCL=0, then SDA=1 and SCL=1.
- R3: Three STOP phases of `HALF_CYCLES` clocks each follow the toggles, in this order: (SDA=0, SCL=0), then (SDA=0, SCL=1), then (SDA=1, SCL=1).
- R4: Until `ready` is high, the core's output and tristate inputs have no effect on the outgoing lines, and `core_sda_i` and `core_scl_i` both read 1.
- R5: `ready` stays 0 during recovery. It rises (2·`TOGGLES`+3)·`HALF_CYCLES`+1 clocks after E0 and stays high until the next reset or request.
- R6: The returned SDA value (`pin_sda_in` AND `aux_sda_i`) is sampled at the edge that ends the last STOP phase. If that value is 0, `fault` goes high at that edge. `ready` follows one clock later whether or not `fault` was set.
- R7: `fault` is sticky. A recovery request does not clear it; only `rst` does.
- R8: Once `ready` is high, `pin_sda_out` equals `core_sda_o` OR `core_sda_t`, as sampled at the previous edge.
- R9: Once `ready` is high, `pin_scl_out` equals `core_scl_o` OR `core_scl_t`, as sampled at the previous edge. `core_scl_i` carries the same value in the same cycle.
- R10: Once `ready` is high, `core_sda_i` equals `pin_sda_in` AND `aux_sda_i`, as sampled at the previous edge.
- R11: A one-cycle `recover_req` restarts the sequence with the timing of R2 to R5. `ready` is still 1 after the request edge and is 0 from the following edge.
- R12: A request sampled at the same edge that ends the last STOP phase takes priority. `ready` does not rise, `fault` is not updated from that sample, and a full new sequence starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts recovery |
| recover_req | input | 1 | One-cycle pulse that restarts recovery |
| core_sda_o | input | 1 | Core SDA output value |
| core_sda_t | input | 1 | Core SDA tristate enable (1 = released) |
| core_scl_o | input | 1 | Core SCL output value |
| core_scl_t | input | 1 | Core SCL tristate enable (1 = released) |
| core_sda_i | output | 1 | SDA returned to the core |
| core_scl_i | output | 1 | SCL returned to the core |
| aux_sda_i | input | 1 | Secondary-bus SDA input; tie to 1 if unused |
| pin_sda_out | output | 1 | SDA toward the companion device |
| pin_scl_out | output | 1 | SCL toward the companion device |
| pin_sda_in | input | 1 | SDA returned by the companion device |
| ready | output | 1 | Recovery finished; pins belong to the core |
| fault | output | 1 | Sticky: returned SDA was low when recovery ended |

## Verification
Two events can fall on the same edge: the end of the last STOP phase, which would both raise `ready` and judge `fault`, and a new recovery request. The bench counts clocks from the start edge and pulses `recover_req` exactly at the edge that ends the final phase, with the returned SDA held low. It then expects `ready` to stay low and `fault` to stay clear, and checks the whole restarted waveform clock by clock against the phase arithmetic. Separate runs cover the stuck-low case without a conflicting request, which must set `fault` and still raise `ready`, and the case where the secondary SDA input alone pulls the returned value low.

// File: rtl/twi_mend_pkg.sv
package twi_mend_pkg;

  typedef enum logic [2:0] {
    SEQ_TOGGLE   = 3'd0,
    SEQ_STOP_LOW = 3'd1,
    SEQ_STOP_CLK = 3'd2,
    SEQ_STOP_REL = 3'd3,
    SEQ_DONE     = 3'd4
  } seq_state_t;

endpackage

// File: rtl/twi_half_timer.sv
module twi_half_timer #(
  parameter int HALF_CYCLES = 4
) (
  input  logic clk,
  input  logic restart,
  output logic tick
);
  localparam int CW = (HALF_CYCLES > 2) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (restart)
      cnt <= '0;
    else if (cnt == LAST)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/twi_recovery_seq.sv
module twi_recovery_seq
  import twi_mend_pkg::*;
#(
  parameter int TOGGLES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  input  logic sda_ret,
  output logic rec_sda,
  output logic rec_scl,
  output logic done,
  output logic fault
);
  localparam int TW = $clog2(TOGGLES + 1);
  localparam logic [TW-1:0] TLAST = TW'(TOGGLES - 1);

  seq_state_t    state;
  logic          phase_hi;
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (restart) begin
      state    <= SEQ_TOGGLE;
      phase_hi <= 1'b0;
      tcnt     <= '0;
    end else if (tick) begin
      case (state)
        SEQ_TOGGLE: begin
          if (!phase_hi) begin
            phase_hi <= 1'b1;
          end else begin
            phase_hi <= 1'b0;
            if (tcnt == TLAST)
              state <= SEQ_STOP_LOW;
            else
              tcnt <= tcnt + 1'b1;
          end
        end
        SEQ_STOP_LOW: state <= SEQ_STOP_CLK;
        SEQ_STOP_CLK: state <= SEQ_STOP_REL;
        SEQ_STOP_REL: state <= SEQ_DONE;
        default:      state <= SEQ_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      fault <= 1'b0;
    else if (!restart && tick && state == SEQ_STOP_REL && !sda_ret)
      fault <= 1'b1;
  end

  always_comb begin
    case (state)
      SEQ_TOGGLE:   begin rec_sda = phase_hi; rec_scl = phase_hi; end
      SEQ_STOP_LOW: begin rec_sda = 1'b0;     rec_scl = 1'b0;     end
      SEQ_STOP_CLK: begin rec_sda = 1'b0;     rec_scl = 1'b1;     end
      default:      begin rec_sda = 1'b1;     rec_scl = 1'b1;     end
    endcase
  end

  assign done = (state == SEQ_DONE);
endmodule

// File: rtl/twi_line_merge.sv
module twi_line_merge (
  input  logic clk,
  input  logic rst,
  input  logic done,
  input  logic rec_sda,
  input  logic rec_scl,
  input  logic core_sda_o,
  input  logic core_sda_t,
  input  logic core_scl_o,
  input  logic core_scl_t,
  input  logic pin_sda_in,
  input  logic aux_sda_i,
  output logic pin_sda_out,
  output logic pin_scl_out,
  output logic core_sda_i,
  output logic core_scl_i,
  output logic ready
);
  logic sda_drive, scl_drive, sda_back;

  always_comb begin
    sda_drive = core_sda_o | core_sda_t;
    scl_drive = core_scl_o | core_scl_t;
    sda_back  = pin_sda_in & aux_sda_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_sda_out <= 1'b1;
      pin_scl_out <= 1'b1;
      core_sda_i  <= 1'b1;
      core_scl_i  <= 1'b1;
      ready       <= 1'b0;
    end else begin
      ready       <= done;
      pin_sda_out <= done ? sda_drive : rec_sda;
      pin_scl_out <= done ? scl_drive : rec_scl;
      core_sda_i  <= done ? sda_back  : 1'b1;
      core_scl_i  <= done ? scl_drive : 1'b1;
    end
  end
endmodule

// File: rtl/twi_line_mender.sv
module twi_line_mender #(
  parameter int TOGGLES     = 9,
  parameter int HALF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic recover_req,
  input  logic core_sda_o,
  input  logic core_sda_t,
  input  logic core_scl_o,
  input  logic core_scl_t,
  output logic core_sda_i,
  output logic core_scl_i,
  input  logic aux_sda_i,
  output logic pin_sda_out,
  output logic pin_scl_out,
  input  logic pin_sda_in,
  output logic ready,
  output logic fault
);
  logic restart, tick, done, rec_sda, rec_scl, sda_ret;

  assign restart = rst | recover_req;
  assign sda_ret = pin_sda_in & aux_sda_i;

  twi_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk     (clk),
    .restart (restart),
    .tick    (tick)
  );

  twi_recovery_seq #(.TOGGLES(TOGGLES)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (tick),
    .sda_ret (sda_ret),
    .rec_sda (rec_sda),
    .rec_scl (rec_scl),
    .done    (done),
    .fault   (fault)
  );

  twi_line_merge u_merge (
    .clk         (clk),
    .rst         (rst),
    .done        (done),
    .rec_sda     (rec_sda),
    .rec_scl     (rec_scl),
    .core_sda_o  (core_sda_o),
    .core_sda_t  (core_sda_t),
    .core_scl_o  (core_scl_o),
    .core_scl_t  (core_scl_t),
    .pin_sda_in  (pin_sda_in),
    .aux_sda_i   (aux_sda_i),
    .pin_sda_out (pin_sda_out),
    .pin_scl_out (pin_scl_out),
    .core_sda_i  (core_sda_i),
    .core_scl_i  (core_scl_i),
    .ready       (ready)
  );
endmodule

// File: rtl/twi_line_mender_chk.sv
module twi_line_mender_chk (
  input logic clk,
  input logic rst,
  input logic recover_req,
  input logic core_sda_o,
  input logic core_sda_t,
  input logic core_scl_o,
  input logic core_scl_t,
  input logic core_sda_i,
  input logic core_scl_i,
  input logic aux_sda_i,
  input logic pin_sda_out,
  input logic pin_scl_out,
  input logic pin_sda_in,
  input logic ready,
  input logic fault
);
  a_r2_scl_low_means_sda_low: assert property (@(posedge clk) disable iff (rst)
    (!ready && !pin_scl_out) |-> !pin_sda_out);

  a_r4_core_sees_high: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (core_sda_i && core_scl_i));

  a_r6_fault_then_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |=> $rose(ready));

  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    (fault && !recover_req) |=> fault);

  a_r8_sda_merge: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready)) |-> (pin_sda_out == ($past(core_sda_o) | $past(core_sda_t))));

  a_r9_scl_merge: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready)) |-> (pin_scl_out == ($past(core_scl_o) | $past(core_scl_t))
                                  && core_scl_i == pin_scl_out));

  a_r10_sda_return: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready)) |-> (core_sda_i == ($past(pin_sda_in) & $past(aux_sda_i))));

  a_r11_req_drops_ready: assert property (@(posedge clk) disable iff (rst)
    recover_req |=> ##1 !ready);
endmodule

bind twi_line_mender twi_line_mender_chk u_chk (.*);

// File: tb/sim_twi_line_mender.sv
module sim_twi_line_mender;
  localparam int CLK_PERIOD = 10;
  localparam int T = 3;
  localparam int D = 3;
  localparam int NCYC = (2 * T + 3) * D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic recover_req = 1'b0;
  logic core_sda_o = 1'b0, core_sda_t = 1'b0, core_scl_o = 1'b0, core_scl_t = 1'b0;
  logic aux_sda_i = 1'b1, pin_sda_in = 1'b0;
  logic core_sda_i, core_scl_i, pin_sda_out, pin_scl_out, ready, fault;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  twi_line_mender #(.TOGGLES(T), .HALF_CYCLES(D)) u0 (
    .clk(clk), .rst(rst), .recover_req(recover_req),
    .core_sda_o(core_sda_o), .core_sda_t(core_sda_t),
    .core_scl_o(core_scl_o), .core_scl_t(core_scl_t),
    .core_sda_i(core_sda_i), .core_scl_i(core_scl_i),
    .aux_sda_i(aux_sda_i), .pin_sda_out(pin_sda_out),
    .pin_scl_out(pin_scl_out), .pin_sda_in(pin_sda_in),
    .ready(ready), .fault(fault)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // {sda, scl} expected k clocks after the start edge, during recovery
  function automatic logic [1:0] exp_lines(input int k);
    int p;
    p = (k - 1) / D;
    if (p < 2 * T) return (p % 2) ? 2'b11 : 2'b00;
    if (p == 2 * T) return 2'b00;
    if (p == 2 * T + 1) return 2'b01;
    return 2'b11;
  endfunction

  // Called just after the start edge E0; the core drives 0 on both lines (ignored, R4)
  task automatic run_recovery(input logic prior_f, input logic exp_f);
    for (int k = 1; k <= NCYC + 1; k++) begin
      logic [1:0] e;
      step();
      if (k <= NCYC) begin
        e = exp_lines(k);
        check(((k - 1) / D < 2 * T) ? "R2" : "R3", "pin_sda_out", pin_sda_out, e[1]);
        check(((k - 1) / D < 2 * T) ? "R2" : "R3", "pin_scl_out", pin_scl_out, e[0]);
        check("R4", "core_sda_i", core_sda_i, 1'b1);
        check("R4", "core_scl_i", core_scl_i, 1'b1);
        check("R5", "ready low", ready, 1'b0);
        check((k == NCYC) ? "R6" : "R7", "fault", fault, (k == NCYC) ? exp_f : prior_f);
      end else begin
        check("R5", "ready high", ready, 1'b1);
        check("R6", "fault held", fault, exp_f);
        check("R8", "pin_sda_out", pin_sda_out, core_sda_o | core_sda_t);
        check("R9", "pin_scl_out", pin_scl_out, core_scl_o | core_scl_t);
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    check("R1", "pin_sda_out", pin_sda_out, 1'b1);
    check("R1", "pin_scl_out", pin_scl_out, 1'b1);
    check("R1", "core_sda_i", core_sda_i, 1'b1);
    check("R1", "core_scl_i", core_scl_i, 1'b1);
    check("R1", "ready", ready, 1'b0);
    check("R1", "fault", fault, 1'b0);
    rst = 1'b0;
  endtask

  task automatic do_request();
    recover_req = 1'b1;
    step();
    recover_req = 1'b0;
    check("R11", "ready after request edge", ready, 1'b1);
  endtask

  initial begin
    // R6: stuck-low return sets fault, ready anyway
    pin_sda_in = 1'b0;
    do_reset();
    run_recovery(1'b0, 1'b1);

    // R7, R11: request with a clean line keeps the sticky fault
    pin_sda_in = 1'b1;
    do_request();
    run_recovery(1'b1, 1'b1);

    // clean run after reset
    do_reset();
    run_recovery(1'b0, 1'b0);

    // R6: secondary SDA low alone makes the returned value low
    aux_sda_i = 1'b0;
    do_request();
    run_recovery(1'b0, 1'b1);
    aux_sda_i = 1'b1;

    // R12: request on the edge that ends the last STOP phase
    pin_sda_in = 1'b0;
    do_reset();
    for (int k = 1; k < NCYC; k++) step();
    recover_req = 1'b1;
    step();
    recover_req = 1'b0;
    pin_sda_in = 1'b1;
    check("R12", "ready not raised", ready, 1'b0);
    check("R12", "fault not updated", fault, 1'b0);
    run_recovery(1'b0, 1'b0);

    // R8, R9, R10: sweep of all core and return input combinations
    for (int v = 0; v < 64; v++) begin
      logic [5:0] b;
      b = 6'(v);
      core_sda_o = b[0]; core_sda_t = b[1];
      core_scl_o = b[2]; core_scl_t = b[3];
      pin_sda_in = b[4]; aux_sda_i  = b[5];
      step();
      check("R8", "pin_sda_out", pin_sda_out, b[0] | b[1]);
      check("R9", "pin_scl_out", pin_scl_out, b[2] | b[3]);
      check("R9", "core_scl_i", core_scl_i, b[2] | b[3]);
      check("R10", "core_sda_i", core_sda_i, b[4] & b[5]);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule